// File: doc/BRIEF.md
# Loop Transmitter with Poll-to-Flag Conversion

This block sits on a ring of stations where each station normally passes the serial line through with a one-bit delay. When the host arms it with the go-active control, the block waits for the next end-of-poll pattern on the receive path. That pattern is a 0 followed by seven 1s in line order. The block turns it into a flag by sending a 0 in place of the seventh 1. From then on it owns the transmit output.

While it owns the line it sends flags until a byte is buffered. It then serialises the frame LSB-first with zero insertion and closes the frame with one flag. At each flag boundary it decides whether to start another frame, keep sending flags, or hand the line back to one-bit-delay repeating. Bytes come in through a valid/ready port with a last-byte marker that ends the frame. One bit moves per cycle in which the bit-clock enable is high.

Top module: `loop_poll_tx`

## Requirements
- R1: Reset leaves the block repeating, with tx_bit at 1, loop_sending at 0, poll_hit at 0 and wr_ready at 1.
- R2: While the block is not sending, each bit-enable cycle copies rx_bit into tx_bit, so the output is the input delayed by one bit time.
- R3: With go_active at 0, an end-of-poll pattern (line order: a 0 and then seven 1s) is repeated unchanged, and loop_sending stays 0.
- R4: With go_active at 1, the seventh 1 of an end-of-poll pattern is sent as 0. In that same bit, loop_sending rises and poll_hit pulses for one clock. poll_hit stands for both the abort-detected and the hunt status.
- R5: After the conversion one full flag (line order 0,1,1,1,1,1,1,0) follows. If a byte is buffered when that flag ends, the data starts right after it.
- R6: While go_active is 1 and no byte is buffered, flags are sent back to back with no bits between them.
- R7: Data bits leave LSB-first, one per bit-enable cycle. A 0 is inserted after every five consecutive 1s of data. The count of 1s carries across the bytes of a frame and also applies after the last data bit. Flags never get an inserted 0.
- R8: A frame ends after a byte written with wr_last at 1, or after any byte that is not followed by a buffered byte when its last bit goes out. The frame is then closed with a single flag.
- R9: At the end of every flag, a buffered byte starts a new frame. Otherwise, if go_active is 1, another flag follows. Otherwise the block returns to repeating. loop_sending falls in the same cycle that the final 0 of that closing flag appears on tx_bit.
- R10: The write port holds one byte. wr_ready is 1 exactly when the holding register is empty, and a byte is taken when wr_valid and wr_ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable, one line bit per high cycle |
| rx_bit | input | 1 | Bit received from the ring |
| go_active | input | 1 | Arms conversion of the next end-of-poll and keeps flags going at frame ends |
| wr_valid | input | 1 | Byte offered on wr_data |
| wr_data | input | BYTE_W | Data byte, sent LSB-first |
| wr_last | input | 1 | Marks the byte as the last byte of its frame |
| wr_ready | output | 1 | Holding register is empty |
| tx_bit | output | 1 | Bit sent onto the ring |
| loop_sending | output | 1 | The block owns the transmit line |
| poll_hit | output | 1 | One-clock pulse when an end-of-poll is converted |

## Verification
The transmit path is driven with single-byte frames chosen to place runs of five 1s at the start, in the middle and at the very end of a byte. This separates zero insertion at each position from the plain LSB-first shift. A non-last byte with nothing after it shows that an underrun closes the frame the same way a marked last byte does. One poll is answered before any data is written and go_active is left high across the frame end. The recorded bit stream then tells flag fill and flag continuation apart from a return to repeating, and a byte pair whose 1s straddle the boundary shows that the count of 1s carries between bytes. End-of-poll patterns sent with go_active low, and single 0/1 bits after each return, confirm plain one-bit repeating.

// File: rtl/loop_poll_tx.sv
module loop_poll_tx #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned RUN_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              go_active,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              wr_ready,
  output logic              tx_bit,
  output logic              loop_sending,
  output logic              poll_hit
);
  localparam int unsigned CW = $clog2(BYTE_W + 1);
  localparam int unsigned OW = $clog2(RUN_MAX + 1);
  localparam logic [6:0] POLL_HEAD = 7'b0111111;

  typedef enum logic [1:0] {S_RPT, S_FLAG, S_DATA} st_t;

  st_t              st_q;
  logic [6:0]       hist_q;
  logic             tx_q, send_q, hit_q;
  logic [BYTE_W-1:0] buf_q, sh_q;
  logic             buf_last_q, buf_v_q, cur_last_q;
  logic [CW-1:0]    bcnt_q;
  logic [2:0]       fcnt_q;
  logic [OW-1:0]    ones_q;

  assign wr_ready     = !buf_v_q;
  assign tx_bit       = tx_q;
  assign loop_sending = send_q;
  assign poll_hit     = hit_q;

  wire accept    = wr_valid && !buf_v_q;
  wire poll_seen = rx_bit && (hist_q == POLL_HEAD);
  wire stuff_now = (ones_q == OW'(RUN_MAX));
  wire dbit      = sh_q[0];
  wire last_pos  = (bcnt_q == CW'(BYTE_W - 1));
  wire run_full  = dbit && (ones_q == OW'(RUN_MAX - 1));
  wire byte_done = stuff_now ? (bcnt_q == CW'(BYTE_W)) : (last_pos && !run_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_RPT;
      hist_q     <= '1;
      tx_q       <= 1'b1;
      send_q     <= 1'b0;
      hit_q      <= 1'b0;
      buf_q      <= '0;
      buf_last_q <= 1'b0;
      buf_v_q    <= 1'b0;
      sh_q       <= '0;
      cur_last_q <= 1'b0;
      bcnt_q     <= '0;
      fcnt_q     <= '0;
      ones_q     <= '0;
    end else begin
      hit_q <= 1'b0;
      if (accept) begin
        buf_q      <= wr_data;
        buf_last_q <= wr_last;
        buf_v_q    <= 1'b1;
      end
      if (bit_en) begin
        hist_q <= {hist_q[5:0], rx_bit};
        case (st_q)
          S_RPT: begin
            if (go_active && poll_seen) begin
              tx_q   <= 1'b0;
              st_q   <= S_FLAG;
              fcnt_q <= '0;
              send_q <= 1'b1;
              hit_q  <= 1'b1;
            end else begin
              tx_q <= rx_bit;
            end
          end
          S_FLAG: begin
            tx_q   <= (fcnt_q != 3'd0) && (fcnt_q != 3'd7);
            fcnt_q <= fcnt_q + 3'd1;
            if (fcnt_q == 3'd7) begin
              if (buf_v_q) begin
                st_q       <= S_DATA;
                sh_q       <= buf_q;
                cur_last_q <= buf_last_q;
                bcnt_q     <= '0;
                ones_q     <= '0;
                buf_v_q    <= 1'b0;
              end else if (!go_active) begin
                st_q   <= S_RPT;
                send_q <= 1'b0;
              end
            end
          end
          S_DATA: begin
            if (stuff_now) begin
              tx_q   <= 1'b0;
              ones_q <= '0;
            end else begin
              tx_q   <= dbit;
              sh_q   <= sh_q >> 1;
              bcnt_q <= bcnt_q + CW'(1);
              ones_q <= dbit ? ones_q + OW'(1) : '0;
            end
            if (byte_done) begin
              if (!cur_last_q && buf_v_q) begin
                sh_q       <= buf_q;
                cur_last_q <= buf_last_q;
                bcnt_q     <= '0;
                buf_v_q    <= 1'b0;
              end else begin
                st_q   <= S_FLAG;
                fcnt_q <= '0;
              end
            end
          end
          default: st_q <= S_RPT;
        endcase
      end
    end
  end
endmodule

// File: rtl/loop_poll_tx_chk.sv
module loop_poll_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic rx_bit,
  input logic go_active,
  input logic wr_valid,
  input logic wr_ready,
  input logic tx_bit,
  input logic loop_sending,
  input logic poll_hit
);
  p_hold_between_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  p_repeat_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !loop_sending && !go_active) |=> (tx_bit == $past(rx_bit)));

  p_start_needs_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_sending) |-> $past(go_active));

  p_hit_flips_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hit |-> (loop_sending && !tx_bit));

  p_hit_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hit |=> !poll_hit);

  p_take_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !bit_en) |=> !wr_ready);

  p_full_waits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !bit_en) |=> !wr_ready);
endmodule

bind loop_poll_tx loop_poll_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
  .go_active(go_active), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .tx_bit(tx_bit), .loop_sending(loop_sending), .poll_hit(poll_hit)
);

// File: tb/loop_poll_tx_tb.sv
module loop_poll_tx_tb;
  logic clk = 1'b0;
  logic rst_n, bit_en, rx_bit, go_active, wr_valid, wr_last;
  logic [7:0] wr_data;
  logic wr_ready, tx_bit, loop_sending, poll_hit;

  always #2 clk = ~clk;

  loop_poll_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .go_active(go_active), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_last(wr_last), .wr_ready(wr_ready), .tx_bit(tx_bit),
    .loop_sending(loop_sending), .poll_hit(poll_hit)
  );

  // {byte, last marker, expected bits from end of conversion to end of closing flag}
  localparam logic [15:0] VEC [0:5] = '{16'h0098, 16'hFF99, 16'h1F99, 16'hF899, 16'h7E99, 16'h5518};

  int n_chk = 0, n_err = 0;
  logic s_tx, s_ls, s_hit;
  logic got [0:255];
  logic exp_b [0:255];
  int exp_n, run1, got_n;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    @(negedge clk); rx_bit = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    s_tx = tx_bit; s_ls = loop_sending; s_hit = poll_hit;
    repeat (2) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b, input logic last);
    @(negedge clk);
    chk(wr_ready, "R10 ready before write", int'(wr_ready), 1);
    wr_valid = 1'b1; wr_data = b; wr_last = last;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic send_poll();
    tick(1'b0);
    for (int i = 0; i < 7; i++) tick(1'b1);
  endtask

  task automatic add_bit(input logic b);
    exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic add_flag();
    for (int i = 0; i < 8; i++) add_bit((i != 0) && (i != 7));
    run1 = 0;
  endtask

  task automatic add_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      add_bit(b[i]);
      run1 = b[i] ? run1 + 1 : 0;
      if (run1 == 5) begin add_bit(1'b0); run1 = 0; end
    end
  endtask

  task automatic compare(input string req);
    int bad = -1;
    chk(got_n == exp_n, req, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && got[i] !== exp_b[i]) bad = i;
    chk(bad < 0, req, bad, -1);
  endtask

  task automatic check_repeat(input string req);
    tick(1'b0); chk(s_tx == 1'b0, req, int'(s_tx), 0);
    tick(1'b1); chk(s_tx == 1'b1, req, int'(s_tx), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b1; go_active = 1'b0;
    wr_valid = 1'b0; wr_data = '0; wr_last = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_bit == 1'b1, "R1 tx idle", int'(tx_bit), 1);
    chk(loop_sending == 1'b0, "R1 not sending", int'(loop_sending), 0);
    chk(poll_hit == 1'b0, "R1 no hit", int'(poll_hit), 0);
    chk(wr_ready == 1'b1, "R1 ready", int'(wr_ready), 1);
    rst_n = 1'b1;

    // R2: plain one-bit repeating
    check_repeat("R2 repeat");
    tick(1'b0); chk(s_tx == 1'b0, "R2 repeat 0", int'(s_tx), 0);

    // R3: poll passes untouched when not armed
    send_poll();
    chk(s_tx == 1'b1, "R3 seventh one kept", int'(s_tx), 1);
    chk(s_ls == 1'b0, "R3 not sending", int'(s_ls), 0);
    chk(s_hit == 1'b0, "R3 no hit", int'(s_hit), 0);
    tick(1'b1); chk(s_ls == 1'b0, "R3 still repeating", int'(s_ls), 0);

    // Table: single-byte frames, byte written before the poll (R4 R5 R7 R8 R9)
    for (int v = 0; v < 6; v++) begin
      go_active = 1'b1;
      push(VEC[v][15:8], VEC[v][7]);
      send_poll();
      chk(s_tx == 1'b0, "R4 poll bit flipped", int'(s_tx), 0);
      chk(s_ls == 1'b1, "R4 sending raised", int'(s_ls), 1);
      chk(s_hit == 1'b1, "R4 hit pulse", int'(s_hit), 1);
      go_active = 1'b0;
      got_n = 0;
      do begin tick(1'b1); got[got_n] = s_tx; got_n++; end while (s_ls && got_n < 200);
      exp_n = 0; run1 = 0;
      add_flag(); add_byte(VEC[v][15:8]); add_flag();
      chk(got_n == int'(VEC[v][6:0]), "R8 frame length", got_n, int'(VEC[v][6:0]));
      compare("R5 R7 R9 frame bits");
      chk(wr_ready == 1'b1, "R10 drained", int'(wr_ready), 1);
      check_repeat("R9 back to repeat");
    end

    // Flag fill, then a two-byte frame, then flags while go stays high (R5 R6 R7 R9)
    go_active = 1'b1;
    send_poll();
    chk(s_hit == 1'b1, "R4 hit on idle poll", int'(s_hit), 1);
    got_n = 0;
    do begin
      tick(1'b1); got[got_n] = s_tx; got_n++;
      if (got_n == 12) push(8'hF0, 1'b0);
      if (got_n == 18) push(8'h01, 1'b1);
      if (got_n == 45) go_active = 1'b0;
    end while (s_ls && got_n < 200);
    exp_n = 0; run1 = 0;
    add_flag(); add_flag(); add_byte(8'hF0); add_byte(8'h01);
    while (exp_n < 45) add_flag();
    compare("R6 R7 R9 fill and continue");
    check_repeat("R9 repeat after fill");

    // R10: held byte waits for a poll
    push(8'h0F, 1'b1);
    chk(wr_ready == 1'b0, "R10 full", int'(wr_ready), 0);
    tick(1'b1); chk(wr_ready == 1'b0, "R10 held while repeating", int'(wr_ready), 0);
    go_active = 1'b1;
    send_poll();
    go_active = 1'b0;
    got_n = 0;
    do begin tick(1'b1); got[got_n] = s_tx; got_n++; end while (s_ls && got_n < 200);
    exp_n = 0; run1 = 0;
    add_flag(); add_byte(8'h0F); add_flag();
    compare("R10 held byte sent");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule